// File: doc/BRIEF.md
# Lane-Split Adder and Accumulator

This block is a registered 48-bit adder, subtracter and accumulator whose internal carry chain can be cut into independent lanes. A static lane mode chooses between one 48-bit lane, two 24-bit lanes or four 12-bit lanes. In the split modes every lane computes its own result, and no carry passes from one lane into the next. The block can add two operands, subtract one from the other, or add one operand to its own registered result to form an accumulator.

The result is held in a register and driven on two ports. One drives local logic. The other is a cascade copy meant for the operand input of a neighbouring unit. A 4-bit carry vector reports the carry out of each lane, at a bit position fixed by the lane mode. A 1-bit cascade carry output and a cascade carry input let several units be chained into wider add, subtract and accumulate operations. All outputs share one synchronous reset and one load enable.

Top module: `lane_split_adder`

## Requirements
- R1: When `rst_p` is high at a rising clock edge, `p_out`, `p_cas`, `carry_out` and `carry_cas_out` become zero after that edge, whatever the value of `ce_p`. Reset takes priority over load.
- R2: When `rst_p` is low and `ce_p` is low at an edge, all four outputs keep their values, whatever the operand, op and mode inputs are.
- R3: `op` selects the operation. The value 0 gives `x_in + y_in`. The value 1 gives `x_in - y_in` in two's complement. The value 2 gives `p_out + x_in`, which uses the registered result. The value 3 behaves like 0. The result appears on `p_out` one edge after it is loaded with `ce_p` high.
- R4: `mode` selects the lane split. The value 0 gives one lane over bits 47:0. The value 1 gives two lanes, 23:0 and 47:24. The value 2 gives four lanes, 11:0, 23:12, 35:24 and 47:36. The value 3 behaves like 0. No carry crosses a lane boundary. A lane that does not start at bit 0 takes a carry-in of 1 when subtracting and 0 otherwise.
- R5: `carry_out` bit k is the carry out of the lane whose top bit is 12*k+11. In the four-lane mode all four bits are valid. In the two-lane mode bits 1 and 3 are valid. In the one-lane mode only bit 3 is valid. Bits that are not valid read 0. For a subtraction, the carry is 1 when the lane does not borrow.
- R6: `cas_cin` enters only bit 0 of the lowest lane. For add and accumulate it is added as a carry. For subtract it acts as a borrow-in, so 1 is subtracted from the lowest lane.
- R7: `carry_cas_out` equals `carry_out[3]` for add and accumulate. For subtract it equals the inverse of `carry_out[3]`, which is the borrow. It can therefore drive `cas_cin` of the next unit directly.
- R8: `p_cas` equals `p_out` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_p | input | 1 | Synchronous reset of all output registers, active high |
| ce_p | input | 1 | Load enable for all output registers |
| mode | input | 2 | Lane split: 0 one lane, 1 two lanes, 2 four lanes, 3 as 0 |
| op | input | 2 | Operation: 0 add, 1 subtract, 2 accumulate, 3 as 0 |
| x_in | input | 48 | First operand; the addend in accumulate |
| y_in | input | 48 | Second operand; the subtrahend in subtract |
| cas_cin | input | 1 | Carry or borrow from the unit below |
| p_out | output | 48 | Registered result |
| p_cas | output | 48 | Cascade copy of the result for a neighbouring unit |
| carry_out | output | 4 | Per-lane carry outputs, placed according to mode |
| carry_cas_out | output | 1 | Carry (add/accumulate) or borrow (subtract) to the next unit |

## Verification
A synchronous reset and a load with `ce_p` high can land on the same edge. The bench provokes this by raising both while the operands would otherwise produce non-zero sums and carries, and it expects every output to read zero. A lane overflow and the cascade carry-in can also fall in the same cycle. The bench drives all-ones operands with `cas_cin` high in each lane mode. It then judges `p_out` and `carry_out` against a reference model that works segment by segment on whole-width integers. That check confirms that the carry stops at each lane boundary and that only the lowest lane sees the cascade input.

// File: rtl/lane_split_pkg.sv
package lane_split_pkg;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'd0,
    MODE_TWO  = 2'd1,
    MODE_FOUR = 2'd2,
    MODE_RSVD = 2'd3
  } lane_mode_e;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_ACC  = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  // Right shift applied to the lane count to get lanes per segment.
  function automatic int seg_shift(input lane_mode_e m);
    case (m)
      MODE_TWO:  return 1;
      MODE_FOUR: return 2;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/lane_map.sv
// Decodes the lane mode into segment start and segment end markers per lane.
module lane_map
  import lane_split_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  lane_mode_e           mode,
  output logic [NUM_LANES-1:0] seg_start,
  output logic [NUM_LANES-1:0] seg_end
);

  always_comb begin
    int seg;
    seg = NUM_LANES >> seg_shift(mode);
    if (seg < 1) seg = 1;
    for (int k = 0; k < NUM_LANES; k++) begin
      seg_start[k] = ((k % seg) == 0);
      seg_end[k]   = (((k + 1) % seg) == 0);
    end
  end

endmodule

// File: rtl/seg_adder.sv
// Ripple of lane-wide adders; the carry is replaced at every segment start.
module seg_adder #(
  parameter int LANE_W    = 12,
  parameter int NUM_LANES = 4,
  localparam int DATA_W   = LANE_W * NUM_LANES
) (
  input  logic [DATA_W-1:0]    a,
  input  logic [DATA_W-1:0]    b,
  input  logic [NUM_LANES-1:0] seg_start,
  input  logic                 lane_cin,
  input  logic                 low_cin,
  output logic [DATA_W-1:0]    sum,
  output logic [NUM_LANES-1:0] lane_cout
);

  function automatic logic [LANE_W:0] lane_add(input logic [LANE_W-1:0] aa,
                                                input logic [LANE_W-1:0] bb,
                                                input logic              ci);
    return {1'b0, aa} + {1'b0, bb} + {{LANE_W{1'b0}}, ci};
  endfunction

  always_comb begin
    logic             c;
    logic [LANE_W:0]  r;
    sum       = '0;
    lane_cout = '0;
    c         = low_cin;
    for (int k = 0; k < NUM_LANES; k++) begin
      if (k != 0 && seg_start[k]) c = lane_cin;
      r = lane_add(a[k*LANE_W +: LANE_W], b[k*LANE_W +: LANE_W], c);
      sum[k*LANE_W +: LANE_W] = r[LANE_W-1:0];
      c            = r[LANE_W];
      lane_cout[k] = c;
    end
  end

endmodule

// File: rtl/result_reg.sv
// Output register bank with synchronous reset and load enable.
module result_reg #(
  parameter int DATA_W    = 48,
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_p,
  input  logic                 ce_p,
  input  logic [DATA_W-1:0]    d_p,
  input  logic [NUM_LANES-1:0] d_co,
  input  logic                 d_cco,
  output logic [DATA_W-1:0]    q_p,
  output logic [DATA_W-1:0]    q_cas,
  output logic [NUM_LANES-1:0] q_co,
  output logic                 q_cco
);

  always_ff @(posedge clk) begin
    if (rst_p) begin
      q_p   <= '0;
      q_cas <= '0;
      q_co  <= '0;
      q_cco <= 1'b0;
    end else if (ce_p) begin
      q_p   <= d_p;
      q_cas <= d_p;
      q_co  <= d_co;
      q_cco <= d_cco;
    end
  end

  // Marks that a reset has been seen, so hold checks never start on power-up values.
  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst_p) armed_q <= 1'b1;
  end

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst_p)
    $past(rst_p) |-> (q_p == '0 && q_cas == '0 && q_co == '0 && !q_cco));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst_p)
    (armed_q && $past(armed_q) && $past(!ce_p) && $past(!rst_p)) |->
      ($stable(q_p) && $stable(q_co) && $stable(q_cco)));

  a_r8_cascade_copy: assert property (@(posedge clk) disable iff (rst_p)
    (armed_q && $past(armed_q)) |-> (q_cas == q_p));

endmodule

// File: rtl/lane_split_adder.sv
module lane_split_adder
  import lane_split_pkg::*;
#(
  parameter int LANE_W    = 12,
  parameter int NUM_LANES = 4,
  localparam int DATA_W   = LANE_W * NUM_LANES
) (
  input  logic                 clk,
  input  logic                 rst_p,
  input  logic                 ce_p,
  input  logic [1:0]           mode,
  input  logic [1:0]           op,
  input  logic [DATA_W-1:0]    x_in,
  input  logic [DATA_W-1:0]    y_in,
  input  logic                 cas_cin,
  output logic [DATA_W-1:0]    p_out,
  output logic [DATA_W-1:0]    p_cas,
  output logic [NUM_LANES-1:0] carry_out,
  output logic                 carry_cas_out
);

  lane_mode_e mode_e;
  op_e        op_sel;
  assign mode_e = lane_mode_e'(mode);
  assign op_sel = op_e'(op);

  // Named internal events, visible to the assertions.
  logic is_sub, is_acc;
  assign is_sub = (op_sel == OP_SUB);
  assign is_acc = (op_sel == OP_ACC);

  logic [NUM_LANES-1:0] seg_start, seg_end;

  lane_map #(.NUM_LANES(NUM_LANES)) map_i (
    .mode      (mode_e),
    .seg_start (seg_start),
    .seg_end   (seg_end)
  );

  // Operand selection: accumulate feeds the registered result back.
  logic [DATA_W-1:0] opnd_a, opnd_b;
  always_comb begin
    opnd_a = is_acc ? p_out : x_in;
    if (is_sub)      opnd_b = ~y_in;
    else if (is_acc) opnd_b = x_in;
    else             opnd_b = y_in;
  end

  logic low_cin;
  assign low_cin = is_sub ? ~cas_cin : cas_cin;

  logic [DATA_W-1:0]    sum_d;
  logic [NUM_LANES-1:0] lane_cout;

  seg_adder #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) add_i (
    .a         (opnd_a),
    .b         (opnd_b),
    .seg_start (seg_start),
    .lane_cin  (is_sub),
    .low_cin   (low_cin),
    .sum       (sum_d),
    .lane_cout (lane_cout)
  );

  logic [NUM_LANES-1:0] co_d;
  logic                 cco_d;
  assign co_d  = lane_cout & seg_end;
  assign cco_d = lane_cout[NUM_LANES-1] ^ is_sub;

  result_reg #(.DATA_W(DATA_W), .NUM_LANES(NUM_LANES)) out_i (
    .clk   (clk),
    .rst_p (rst_p),
    .ce_p  (ce_p),
    .d_p   (sum_d),
    .d_co  (co_d),
    .d_cco (cco_d),
    .q_p   (p_out),
    .q_cas (p_cas),
    .q_co  (carry_out),
    .q_cco (carry_cas_out)
  );

  a_r7_cascade_carry: assert property (@(posedge clk) disable iff (rst_p)
    ($past(ce_p) && $past(!rst_p)) |->
      (carry_cas_out == (carry_out[NUM_LANES-1] ^ $past(is_sub))));

  a_r5_two_lane_unused: assert property (@(posedge clk) disable iff (rst_p)
    ($past(ce_p) && $past(!rst_p) && $past(mode_e == MODE_TWO)) |->
      (!carry_out[0] && !carry_out[2]));

  a_r5_one_lane_unused: assert property (@(posedge clk) disable iff (rst_p)
    ($past(ce_p) && $past(!rst_p) &&
     ($past(mode_e == MODE_ONE) || $past(mode_e == MODE_RSVD))) |->
      (carry_out[NUM_LANES-2:0] == '0));

endmodule

// File: tb/lane_split_adder_tb_top.sv
module lane_split_adder_tb_top;

  logic        clk = 1'b0;
  logic        rst_p = 1'b1;
  logic        ce_p = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  op = 2'd0;
  logic [47:0] x_in = '0;
  logic [47:0] y_in = '0;
  logic        cas_cin = 1'b0;
  logic [47:0] p_out, p_cas;
  logic [3:0]  carry_out;
  logic        carry_cas_out;

  always #5 clk = ~clk;

  lane_split_adder dut_i (
    .clk(clk), .rst_p(rst_p), .ce_p(ce_p), .mode(mode), .op(op),
    .x_in(x_in), .y_in(y_in), .cas_cin(cas_cin),
    .p_out(p_out), .p_cas(p_cas), .carry_out(carry_out),
    .carry_cas_out(carry_cas_out)
  );

  typedef struct {
    logic [47:0] p;
    logic [3:0]  co;
    logic        cco;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  logic [47:0] m_p   = '0;
  logic [3:0]  m_co  = '0;
  logic        m_cco = 1'b0;

  // Reference: treat each segment as one wide integer.
  task automatic model(input int md, input int o, input logic [47:0] x,
                       input logic [47:0] y, input logic ci);
    logic        sub, acc, c;
    logic [47:0] a, b, r, mask, as, bs;
    logic [48:0] t;
    logic [3:0]  co;
    int          w, nseg;
    sub  = (o == 1);
    acc  = (o == 2);
    a    = acc ? m_p : x;
    b    = sub ? ~y : (acc ? x : y);
    w    = (md == 1) ? 24 : (md == 2) ? 12 : 48;
    nseg = 48 / w;
    mask = (48'h1 << w) - 48'h1;
    r    = '0;
    co   = '0;
    c    = sub ? ~ci : ci;
    for (int s = 0; s < nseg; s++) begin
      as = (a >> (s * w)) & mask;
      bs = (b >> (s * w)) & mask;
      t  = {1'b0, as} + {1'b0, bs} + {48'h0, c};
      r  = r | ((t[47:0] & mask) << (s * w));
      co[(s + 1) * (4 / nseg) - 1] = t[w];
      c = sub;
    end
    m_p   = r;
    m_co  = co;
    m_cco = co[3] ^ sub;
  endtask

  task automatic step(input logic r, input logic ce, input int md, input int o,
                      input logic [47:0] x, input logic [47:0] y,
                      input logic ci, input string tag);
    exp_t e;
    @(negedge clk);
    rst_p = r; ce_p = ce; mode = 2'(md); op = 2'(o);
    x_in = x; y_in = y; cas_cin = ci;
    if (r) begin
      m_p = '0; m_co = '0; m_cco = 1'b0;
    end else if (ce) begin
      model(md, o, x, y, ci);
    end
    e.p = m_p; e.co = m_co; e.cco = m_cco; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: one expected item per edge, sampled 2 ns after the edge.
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(p_out == e.p, e.tag, "p_out", p_out, e.p);
        check(carry_out == e.co, e.tag, "carry_out", {44'h0, carry_out}, {44'h0, e.co});
        check(p_cas == e.p, "R8", "p_cas", p_cas, e.p);
        check(carry_cas_out == e.cco, "R7", "carry_cas_out",
              {47'h0, carry_cas_out}, {47'h0, e.cco});
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    // R1: reset with load disabled
    step(1, 0, 0, 0, 48'h0, 48'h0, 0, "R1");
    // R3: plain adds in one lane
    step(0, 1, 0, 0, 48'h123456789ABC, 48'h111111111111, 0, "R3");
    step(0, 1, 0, 3, 48'h000000000005, 48'h000000000007, 0, "R3");
    // R5: full-width overflow, only bit 3 reported
    step(0, 1, 0, 0, 48'hFFFFFFFFFFFF, 48'h000000000001, 0, "R5");
    // R4: carry ripples across the 24-bit boundary in one-lane mode
    step(0, 1, 0, 0, 48'h000000FFFFFF, 48'h000000000001, 0, "R4");
    // R4: the same sum in two-lane mode stops at bit 24
    step(0, 1, 1, 0, 48'h000000FFFFFF, 48'h000000000001, 0, "R4");
    step(0, 1, 1, 0, 48'hFFFFFFFFFFFF, 48'h000001000001, 0, "R5");
    // R5: every 12-bit lane overflows
    step(0, 1, 2, 0, 48'hFFFFFFFFFFFF, 48'h001001001001, 0, "R5");
    step(0, 1, 2, 0, 48'h000FFF000FFF, 48'h001001001001, 0, "R4");
    step(0, 1, 2, 0, 48'hFFF000FFF000, 48'h001000001000, 0, "R5");
    // R4: reserved mode value acts as one lane
    step(0, 1, 3, 0, 48'h000000000FFF, 48'h000000000001, 0, "R4");
    // R3: subtraction in each mode
    step(0, 1, 0, 1, 48'h000000000005, 48'h000000000007, 0, "R3");
    step(0, 1, 1, 1, 48'h000005000009, 48'h000007000002, 0, "R3");
    step(0, 1, 2, 1, 48'h005009000123, 48'h007002000123, 0, "R4");
    // R6: cascade carry in, all-ones per lane, each mode
    step(0, 1, 0, 0, 48'hFFFFFFFFFFFF, 48'h000000000000, 1, "R6");
    step(0, 1, 1, 0, 48'hFFFFFFFFFFFF, 48'h000000000000, 1, "R6");
    step(0, 1, 2, 0, 48'hFFFFFFFFFFFF, 48'h000000000000, 1, "R6");
    // R6: borrow-in during subtraction
    step(0, 1, 0, 1, 48'h000000000010, 48'h000000000010, 1, "R6");
    step(0, 1, 2, 1, 48'h010010010010, 48'h010010010010, 1, "R6");
    // R3: accumulate from zero in four-lane mode
    step(1, 0, 2, 2, 48'h0, 48'h0, 0, "R1");
    step(0, 1, 2, 2, 48'h800800800800, 48'h0, 0, "R3");
    step(0, 1, 2, 2, 48'h7FF7FF7FF7FF, 48'h0, 0, "R3");
    step(0, 1, 2, 2, 48'h001001001001, 48'h0, 0, "R5");
    // R2: load disabled, inputs changed
    step(0, 0, 0, 0, 48'h123456789ABC, 48'hFEDCBA987654, 1, "R2");
    step(0, 0, 1, 2, 48'hFFFFFFFFFFFF, 48'hFFFFFFFFFFFF, 0, "R2");
    step(0, 1, 0, 2, 48'h000000000003, 48'h0, 0, "R3");
    // R1: reset and load on the same edge
    step(1, 1, 2, 0, 48'hFFFFFFFFFFFF, 48'h001001001001, 1, "R1");
    step(0, 0, 0, 0, 48'h0, 48'h0, 0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule